// File: doc/BRIEF.md
# Debug Test Access Port with Chain Selection

This block is the serial test access port of an on-chip debug unit. It runs on the system clock. A synchronous enable input marks the cycles that stand for a rising test-clock edge, so the whole port stays in one clock domain. On each such cycle the sixteen-state test access state machine samples the mode-select input and moves. The instruction register, the identification register, the bypass bit and a scan-chain selection register are loaded, shifted and committed as the state machine passes through its capture, shift and update states.

A debugger first loads an instruction through the instruction path, then scans data through the register that the instruction picks. One instruction gives access to a 5-bit chain-number register. The committed chain number is exported, so that surrounding debug logic can route further scans. Another instruction forwards the serial stream to one external scan chain and returns that chain's output. The current state, the current instruction and the chain number are all exported as plain buses.

Top module: `dbg_tap_ctrl`

## Requirements
- R1: The state machine moves only on cycles where `tck_en` is high, following the standard test access port graph on `tms`. `tap_state` encodes the states as: reset 0xF, idle 0xC, DR-select 0x7, DR-capture 0x6, DR-shift 0x2, DR-exit1 0x1, DR-pause 0x3, DR-exit2 0x0, DR-update 0x5, IR-select 0x4, IR-capture 0xE, IR-shift 0xA, IR-exit1 0x9, IR-pause 0xB, IR-exit2 0x8, IR-update 0xD.
- R2: A low level on `rst_n` clears the port at once, without waiting for a clock. After it, `tap_state` is 0xF, `cur_instr` is 0xE, `chain_num` is 0, `tdo` is 0 and `tdo_en_n` is 1.
- R3: Five consecutive enabled steps with `tms` high put the machine in the reset state (0xF) from any state. Entering that state makes `cur_instr` 0xE.
- R4: An enabled step out of IR-capture loads the pattern 0001 into the instruction shifter. Shifting moves the shifter toward its LSB, and `tdi` enters at the MSB. `cur_instr` changes only on an enabled step taken from IR-update, or on entry to the reset state.
- R5: Instruction 0x2 selects the 5-bit chain register. Its capture loads the present `chain_num`. `chain_num` changes only on an enabled step taken from DR-update while 0x2 is the instruction, and it then takes the shifted value.
- R6: Instruction 0xE selects a 32-bit register. Its capture loads `id_code`, which is then shifted out LSB first.
- R7: Instruction 0xF, and every code other than 0x0, 0x2 and 0xE, selects a 1-bit bypass register that captures 0. A scan through it returns `tdi` one step late.
- R8: Each enabled step taken in IR-shift or DR-shift registers the bit leaving the selected register onto `tdo` and drives `tdo_en_n` low. Any other enabled step drives `tdo_en_n` high. Between enabled steps both outputs hold.
- R9: While the instruction is 0x0, `ext_si` follows `tdi`, and each enabled DR-shift step registers `ext_so` onto `tdo`. Under any other instruction `ext_si` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset of all port state |
| tck_en | input | 1 | Marks a test-clock step |
| tms | input | 1 | Mode select, sampled on enabled steps |
| tdi | input | 1 | Serial data in |
| id_code | input | 32 | Identification value captured under instruction 0xE |
| ext_so | input | 1 | Serial output of the external chain |
| tdo | output | 1 | Registered serial data out |
| tdo_en_n | output | 1 | Low while `tdo` carries shifted data |
| ext_si | output | 1 | Serial input to the external chain |
| tap_state | output | 4 | Encoded current state |
| cur_instr | output | 4 | Committed instruction |
| chain_num | output | 5 | Committed scan-chain number |

## Verification
The last bit of a scan and the exit from the shift state fall on one enabled step. On that step `tdo` must take the final bit while `tdo_en_n` stays low, and the enable must rise only on the step after. Every scan in the bench provokes this, and some scans also pass through the pause states in mid-stream, where the enable must rise and fall again without losing a bit. A behavioural reference model built on bit queues predicts all outputs on every clock, while idle cycles with random `tms` and `tdi` are inserted between enabled steps.

// File: rtl/dbg_tap_pkg.sv
`timescale 1ns/1ps
package dbg_tap_pkg;

   // State codes are exported on tap_state; values are fixed by R1.
   typedef enum logic [3:0] {
      ST_RESET    = 4'hF,
      ST_IDLE     = 4'hC,
      ST_DR_SEL   = 4'h7,
      ST_DR_CAP   = 4'h6,
      ST_DR_SHIFT = 4'h2,
      ST_DR_EX1   = 4'h1,
      ST_DR_PAUSE = 4'h3,
      ST_DR_EX2   = 4'h0,
      ST_DR_UPD   = 4'h5,
      ST_IR_SEL   = 4'h4,
      ST_IR_CAP   = 4'hE,
      ST_IR_SHIFT = 4'hA,
      ST_IR_EX1   = 4'h9,
      ST_IR_PAUSE = 4'hB,
      ST_IR_EX2   = 4'h8,
      ST_IR_UPD   = 4'hD
   } tap_state_e;

   function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
      tap_state_e r;
      case (s)
         ST_RESET:    r = m ? ST_RESET  : ST_IDLE;
         ST_IDLE:     r = m ? ST_DR_SEL : ST_IDLE;
         ST_DR_SEL:   r = m ? ST_IR_SEL : ST_DR_CAP;
         ST_DR_CAP:   r = m ? ST_DR_EX1 : ST_DR_SHIFT;
         ST_DR_SHIFT: r = m ? ST_DR_EX1 : ST_DR_SHIFT;
         ST_DR_EX1:   r = m ? ST_DR_UPD : ST_DR_PAUSE;
         ST_DR_PAUSE: r = m ? ST_DR_EX2 : ST_DR_PAUSE;
         ST_DR_EX2:   r = m ? ST_DR_UPD : ST_DR_SHIFT;
         ST_DR_UPD:   r = m ? ST_DR_SEL : ST_IDLE;
         ST_IR_SEL:   r = m ? ST_RESET  : ST_IR_CAP;
         ST_IR_CAP:   r = m ? ST_IR_EX1 : ST_IR_SHIFT;
         ST_IR_SHIFT: r = m ? ST_IR_EX1 : ST_IR_SHIFT;
         ST_IR_EX1:   r = m ? ST_IR_UPD : ST_IR_PAUSE;
         ST_IR_PAUSE: r = m ? ST_IR_EX2 : ST_IR_PAUSE;
         ST_IR_EX2:   r = m ? ST_IR_UPD : ST_IR_SHIFT;
         ST_IR_UPD:   r = m ? ST_DR_SEL : ST_IDLE;
         default:     r = ST_RESET;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/dbg_tap_fsm.sv
`timescale 1ns/1ps
module dbg_tap_fsm
   import dbg_tap_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tck_en,
   input  logic       tms,
   output tap_state_e state_q,
   output tap_state_e state_nx
);

   assign state_nx = tap_next(state_q, tms);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      state_q <= ST_RESET;
      else if (tck_en) state_q <= state_nx;
   end

endmodule

// File: rtl/dbg_tap_ir.sv
`timescale 1ns/1ps
module dbg_tap_ir
   import dbg_tap_pkg::*;
#(
   parameter int              IR_W   = 4,
   parameter logic [IR_W-1:0] CAPT   = 4'b0001,
   parameter logic [IR_W-1:0] RST_OP = 4'hE
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tck_en,
   input  logic            tdi,
   input  tap_state_e      state_q,
   input  tap_state_e      state_nx,
   output logic [IR_W-1:0] instr_q,
   output logic            ir_so
);

   logic [IR_W-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q    <= CAPT;
         instr_q <= RST_OP;
      end else if (tck_en) begin
         if (state_q == ST_IR_CAP)
            sh_q <= CAPT;
         else if (state_q == ST_IR_SHIFT)
            sh_q <= {tdi, sh_q[IR_W-1:1]};
         if (state_nx == ST_RESET)
            instr_q <= RST_OP;
         else if (state_q == ST_IR_UPD)
            instr_q <= sh_q;
      end
   end

   assign ir_so = sh_q[0];

endmodule

// File: rtl/dbg_tap_shreg.sv
`timescale 1ns/1ps
module dbg_tap_shreg #(
   parameter int W = 32
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cap,
   input  logic         shf,
   input  logic [W-1:0] cap_val,
   input  logic         sin,
   output logic         so
);

   logic [W-1:0] q;

   generate
      if (W == 1) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   q <= '0;
            else if (cap) q <= cap_val;
            else if (shf) q <= sin;
         end
      end else begin : g_vec
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   q <= '0;
            else if (cap) q <= cap_val;
            else if (shf) q <= {sin, q[W-1:1]};
         end
      end
   endgenerate

   assign so = q[0];

endmodule

// File: rtl/dbg_tap_dr.sv
`timescale 1ns/1ps
module dbg_tap_dr
   import dbg_tap_pkg::*;
#(
   parameter int              IR_W      = 4,
   parameter int              CHAIN_W   = 5,
   parameter int              ID_W      = 32,
   parameter logic [IR_W-1:0] OP_IDCODE = 4'hE,
   parameter logic [IR_W-1:0] OP_CHSEL  = 4'h2,
   parameter logic [IR_W-1:0] OP_EXT    = 4'h0,
   parameter bit              EXT_EN    = 1'b1
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tck_en,
   input  logic               tdi,
   input  tap_state_e         state_q,
   input  logic [IR_W-1:0]    instr_q,
   input  logic [ID_W-1:0]    id_code,
   input  logic               ext_so,
   output logic [CHAIN_W-1:0] chain_q,
   output logic               dr_so,
   output logic               ext_si
);

   logic sel_id, sel_ch, sel_ex, sel_byp;
   logic cap, shf;
   logic id_so, byp_so;
   logic [CHAIN_W-1:0] ch_sh;

   assign sel_id  = (instr_q == OP_IDCODE);
   assign sel_ch  = (instr_q == OP_CHSEL);

   generate
      if (EXT_EN) begin : g_ext
         assign sel_ex = (instr_q == OP_EXT);
      end else begin : g_noext
         assign sel_ex = 1'b0;
      end
   endgenerate

   assign sel_byp = !(sel_id || sel_ch || sel_ex);
   assign cap     = tck_en && (state_q == ST_DR_CAP);
   assign shf     = tck_en && (state_q == ST_DR_SHIFT);

   dbg_tap_shreg #(.W(ID_W)) id_reg_i (
      .clk(clk), .rst_n(rst_n), .cap(cap && sel_id), .shf(shf && sel_id),
      .cap_val(id_code), .sin(tdi), .so(id_so)
   );

   dbg_tap_shreg #(.W(1)) byp_reg_i (
      .clk(clk), .rst_n(rst_n), .cap(cap && sel_byp), .shf(shf && sel_byp),
      .cap_val(1'b0), .sin(tdi), .so(byp_so)
   );

   // Chain selection: shifter plus committed copy
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ch_sh   <= '0;
         chain_q <= '0;
      end else if (sel_ch) begin
         if (cap)
            ch_sh <= chain_q;
         else if (shf)
            ch_sh <= {tdi, ch_sh[CHAIN_W-1:1]};
         if (tck_en && state_q == ST_DR_UPD)
            chain_q <= ch_sh;
      end
   end

   always_comb begin
      if (sel_ex)      dr_so = ext_so;
      else if (sel_id) dr_so = id_so;
      else if (sel_ch) dr_so = ch_sh[0];
      else             dr_so = byp_so;
   end

   assign ext_si = sel_ex ? tdi : 1'b0;

endmodule

// File: rtl/dbg_tap_ctrl.sv
`timescale 1ns/1ps
module dbg_tap_ctrl
   import dbg_tap_pkg::*;
#(
   parameter int              IR_W      = 4,
   parameter int              CHAIN_W   = 5,
   parameter int              ID_W      = 32,
   parameter logic [IR_W-1:0] OP_IDCODE = 4'hE,
   parameter logic [IR_W-1:0] OP_BYPASS = 4'hF,
   parameter logic [IR_W-1:0] OP_CHSEL  = 4'h2,
   parameter logic [IR_W-1:0] OP_EXT    = 4'h0,
   parameter logic [IR_W-1:0] IR_CAPT   = 4'b0001,
   parameter bit              EXT_EN    = 1'b1
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tck_en,
   input  logic               tms,
   input  logic               tdi,
   input  logic [ID_W-1:0]    id_code,
   input  logic               ext_so,
   output logic               tdo,
   output logic               tdo_en_n,
   output logic               ext_si,
   output logic [3:0]         tap_state,
   output logic [IR_W-1:0]    cur_instr,
   output logic [CHAIN_W-1:0] chain_num
);

   localparam int NUM_OPS = 4;

   generate
      if (IR_W < 2) begin : g_bad_ir
         $error("dbg_tap_ctrl: IR_W must be at least 2");
      end
      if (CHAIN_W < 1 || ID_W < 1) begin : g_bad_dr
         $error("dbg_tap_ctrl: data register widths must be positive");
      end
      if (IR_CAPT[0] != 1'b1 || IR_CAPT[1] != 1'b0) begin : g_bad_capt
         $error("dbg_tap_ctrl: IR capture pattern must end in binary 01");
      end
      if (NUM_OPS > (1 << IR_W) || OP_IDCODE == OP_CHSEL || OP_IDCODE == OP_EXT ||
          OP_CHSEL == OP_EXT || OP_BYPASS == OP_IDCODE || OP_BYPASS == OP_CHSEL ||
          OP_BYPASS == OP_EXT) begin : g_bad_ops
         $error("dbg_tap_ctrl: instruction codes must be distinct");
      end
   endgenerate

   tap_state_e st_q, st_nx;
   logic       ir_so, dr_so;

   dbg_tap_fsm fsm_i (
      .clk(clk), .rst_n(rst_n), .tck_en(tck_en), .tms(tms),
      .state_q(st_q), .state_nx(st_nx)
   );

   dbg_tap_ir #(.IR_W(IR_W), .CAPT(IR_CAPT), .RST_OP(OP_IDCODE)) ir_i (
      .clk(clk), .rst_n(rst_n), .tck_en(tck_en), .tdi(tdi),
      .state_q(st_q), .state_nx(st_nx), .instr_q(cur_instr), .ir_so(ir_so)
   );

   dbg_tap_dr #(
      .IR_W(IR_W), .CHAIN_W(CHAIN_W), .ID_W(ID_W), .OP_IDCODE(OP_IDCODE),
      .OP_CHSEL(OP_CHSEL), .OP_EXT(OP_EXT), .EXT_EN(EXT_EN)
   ) dr_i (
      .clk(clk), .rst_n(rst_n), .tck_en(tck_en), .tdi(tdi), .state_q(st_q),
      .instr_q(cur_instr), .id_code(id_code), .ext_so(ext_so),
      .chain_q(chain_num), .dr_so(dr_so), .ext_si(ext_si)
   );

   // Output stage: acts as the falling test-clock edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tdo      <= 1'b0;
         tdo_en_n <= 1'b1;
      end else if (tck_en) begin
         if (st_q == ST_IR_SHIFT) begin
            tdo      <= ir_so;
            tdo_en_n <= 1'b0;
         end else if (st_q == ST_DR_SHIFT) begin
            tdo      <= dr_so;
            tdo_en_n <= 1'b0;
         end else begin
            tdo_en_n <= 1'b1;
         end
      end
   end

   assign tap_state = st_q;

endmodule

// File: rtl/dbg_tap_chk.sv
`timescale 1ns/1ps
module dbg_tap_chk #(
   parameter int              IR_W      = 4,
   parameter int              CHAIN_W   = 5,
   parameter logic [IR_W-1:0] OP_IDCODE = 4'hE,
   parameter logic [IR_W-1:0] OP_CHSEL  = 4'h2,
   parameter logic [IR_W-1:0] OP_EXT    = 4'h0
)(
   input logic               clk,
   input logic               rst_n,
   input logic               tck_en,
   input logic               tms,
   input logic               tdi,
   input logic               tdo_en_n,
   input logic               ext_si,
   input logic [3:0]         tap_state,
   input logic [IR_W-1:0]    cur_instr,
   input logic [CHAIN_W-1:0] chain_num
);

   logic [2:0] hi_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      hi_run <= '0;
      else if (tck_en) hi_run <= !tms ? 3'd0 : (hi_run == 3'd5 ? 3'd5 : hi_run + 3'd1);
   end

   assert_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !tck_en |=> $stable(tap_state));

   assert_five_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_run == 3'd5) |-> (tap_state == 4'hF && cur_instr == OP_IDCODE));

   assert_instr_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cur_instr) |-> (($past(tck_en) && $past(tap_state) == 4'hD) || tap_state == 4'hF));

   assert_chain_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(chain_num) |-> ($past(tck_en) && $past(tap_state) == 4'h5 &&
                               $past(cur_instr) == OP_CHSEL));

   assert_tdo_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tdo_en_n) |-> ($past(tck_en) && ($past(tap_state) == 4'h2 || $past(tap_state) == 4'hA)));

   assert_tdo_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tdo_en_n) |-> ($past(tck_en) && $past(tap_state) != 4'h2 && $past(tap_state) != 4'hA));

   assert_ext_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_instr != OP_EXT) |-> !ext_si);

   assert_ext_fwd_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_instr == OP_EXT) |-> (ext_si == tdi));

endmodule

bind dbg_tap_ctrl dbg_tap_chk #(
   .IR_W(IR_W), .CHAIN_W(CHAIN_W), .OP_IDCODE(OP_IDCODE),
   .OP_CHSEL(OP_CHSEL), .OP_EXT(OP_EXT)
) chk_i (
   .clk(clk), .rst_n(rst_n), .tck_en(tck_en), .tms(tms), .tdi(tdi),
   .tdo_en_n(tdo_en_n), .ext_si(ext_si), .tap_state(tap_state),
   .cur_instr(cur_instr), .chain_num(chain_num)
);

// File: tb/dbg_tap_ctrl_tb_top.sv
`timescale 1ns/1ps
module dbg_tap_ctrl_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tck_en = 1'b0;
   logic        tms = 1'b1;
   logic        tdi = 1'b0;
   logic [31:0] id_code = 32'h4BA0_0477;
   logic        ext_so = 1'b0;
   logic        tdo, tdo_en_n, ext_si;
   logic [3:0]  tap_state, cur_instr;
   logic [4:0]  chain_num;

   int n_chk = 0;
   int n_fail = 0;
   int gap_sel = 0;
   bit done = 1'b0;
   logic [15:0] lfsr = 16'hACE1;

   always #2 clk = ~clk;

   dbg_tap_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .tck_en(tck_en), .tms(tms), .tdi(tdi),
      .id_code(id_code), .ext_so(ext_so), .tdo(tdo), .tdo_en_n(tdo_en_n),
      .ext_si(ext_si), .tap_state(tap_state), .cur_instr(cur_instr),
      .chain_num(chain_num)
   );

   // External chain stand-in: pseudo-random serial output
   always @(negedge clk) begin
      lfsr   <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ext_so <= lfsr[15];
   end

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // ---------------- reference model ----------------
   int g0[16], g1[16];
   int m_st = 15, m_instr = 14, m_chain = 0;
   bit m_tdo = 0, m_en_n = 1;
   bit ir_q[$];
   bit dr_q[$];

   initial begin
      g0[15]=12; g1[15]=15;  g0[12]=12; g1[12]=7;   g0[7]=6;   g1[7]=4;
      g0[6]=2;   g1[6]=1;    g0[2]=2;   g1[2]=1;    g0[1]=3;   g1[1]=5;
      g0[3]=3;   g1[3]=0;    g0[0]=2;   g1[0]=5;    g0[5]=12;  g1[5]=7;
      g0[4]=14;  g1[4]=15;   g0[14]=10; g1[14]=9;   g0[10]=10; g1[10]=9;
      g0[9]=11;  g1[9]=13;   g0[11]=11; g1[11]=8;   g0[8]=10;  g1[8]=13;
      g0[13]=12; g1[13]=7;
   end

   always begin
      @(posedge clk);
      if (!rst_n) begin
         m_st = 15; m_instr = 14; m_chain = 0; m_tdo = 0; m_en_n = 1;
         ir_q = {}; dr_q = {};
      end else if (tck_en) begin
         int nst;
         if (m_st == 10) begin
            m_tdo = ir_q.pop_front(); ir_q.push_back(tdi); m_en_n = 0;
         end else if (m_st == 2) begin
            if (m_instr == 0) m_tdo = ext_so;
            else begin m_tdo = dr_q.pop_front(); dr_q.push_back(tdi); end
            m_en_n = 0;
         end else m_en_n = 1;
         if (m_st == 14) ir_q = {1'b1, 1'b0, 1'b0, 1'b0};
         if (m_st == 6) begin
            dr_q = {};
            if (m_instr == 14)      for (int i = 0; i < 32; i++) dr_q.push_back(id_code[i]);
            else if (m_instr == 2)  for (int i = 0; i < 5; i++) dr_q.push_back(m_chain[i]);
            else if (m_instr != 0)  dr_q.push_back(1'b0);
         end
         if (m_st == 5 && m_instr == 2) begin
            m_chain = 0;
            for (int i = 0; i < 5; i++) m_chain += int'(dr_q[i]) << i;
         end
         nst = tms ? g1[m_st] : g0[m_st];
         if (nst == 15) m_instr = 14;
         else if (m_st == 13) begin
            m_instr = 0;
            for (int i = 0; i < 4; i++) m_instr += int'(ir_q[i]) << i;
         end
         m_st = nst;
      end
      #1;
      check("R1", "tap_state", 32'(tap_state), m_st);
      check("R4", "cur_instr", 32'(cur_instr), m_instr);
      check("R5", "chain_num", 32'(chain_num), m_chain);
      check("R8", "tdo_en_n", 32'(tdo_en_n), 32'(m_en_n));
      if (!m_en_n) check("R8", "tdo", 32'(tdo), 32'(m_tdo));
      check("R9", "ext_si", 32'(ext_si), (m_instr == 0) ? 32'(tdi) : 32'd0);
   end

   // ---------------- stimulus ----------------
   task automatic step(input logic m, input logic d, output logic so);
      @(negedge clk);
      tck_en = 1'b1; tms = m; tdi = d;
      @(negedge clk);
      tck_en = 1'b0; so = tdo;
      repeat (gap_sel % 3) begin
         tms = 1'($urandom); tdi = 1'($urandom);
         @(negedge clk);
      end
      gap_sel++;
   endtask

   task automatic load_ir(input logic [3:0] v, output logic [3:0] cap);
      logic s;
      step(1, 0, s); step(1, 0, s); step(0, 0, s); step(0, 0, s);
      for (int i = 0; i < 4; i++) begin step(i == 3, v[i], s); cap[i] = s; end
      step(1, 0, s); step(0, 0, s);
   endtask

   task automatic scan_dr(input int n, input logic [31:0] din, input int pause_at,
                          output logic [31:0] dout);
      logic s;
      dout = '0;
      step(1, 0, s); step(0, 0, s); step(0, 0, s);
      for (int i = 0; i < n; i++) begin
         step((i == n - 1) || (i == pause_at), din[i], s);
         dout[i] = s;
         if (i == pause_at && i != n - 1) begin
            step(0, 0, s); step(0, 0, s); step(1, 0, s); step(0, 0, s);
         end
      end
      step(1, 0, s); step(0, 0, s);
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual=hung expected=finished");
         finish_run();
      end
   end

   initial begin
      logic [3:0]  cap;
      logic [31:0] dout;
      logic [3:0]  st_before;
      logic        s;

      repeat (3) @(negedge clk);
      check("R2", "reset tap_state", 32'(tap_state), 32'hF);
      check("R2", "reset cur_instr", 32'(cur_instr), 32'hE);
      check("R2", "reset chain_num", 32'(chain_num), 32'h0);
      check("R2", "reset tdo_en_n", 32'(tdo_en_n), 32'h1);
      check("R2", "reset tdo", 32'(tdo), 32'h0);
      rst_n = 1'b1;

      // R1: disabled cycles with toggling tms do not move the state
      st_before = tap_state;
      repeat (10) begin @(negedge clk); tms = ~tms; end
      check("R1", "gated state", 32'(tap_state), 32'(st_before));
      step(0, 0, s);
      check("R1", "idle after step", 32'(tap_state), 32'hC);

      // R6: identification readout right after reset
      scan_dr(32, 32'h1234_5678, -1, dout);
      check("R6", "idcode readout", dout, id_code);
      id_code = 32'h8000_0001;
      scan_dr(32, 32'h0, 13, dout);
      check("R6", "idcode readout with pause", dout, 32'h8000_0001);

      // R4: capture pattern and instruction commit
      load_ir(4'h2, cap);
      check("R4", "ir capture", 32'(cap), 32'h1);
      check("R4", "instr chain select", 32'(cur_instr), 32'h2);

      // R5: chain register round trip
      scan_dr(5, 32'd13, -1, dout);
      check("R5", "chain old value", dout, 32'd0);
      check("R5", "chain committed", 32'(chain_num), 32'd13);
      scan_dr(5, 32'd22, 2, dout);
      check("R5", "chain old value 13", dout, 32'd13);
      check("R5", "chain committed 22", 32'(chain_num), 32'd22);

      // R7: unknown code and bypass code
      load_ir(4'h5, cap);
      check("R7", "instr unknown", 32'(cur_instr), 32'h5);
      scan_dr(8, 32'hB5, -1, dout);
      check("R7", "bypass unknown code", dout, 32'h6A);
      check("R7", "chain untouched", 32'(chain_num), 32'd22);
      load_ir(4'hF, cap);
      scan_dr(8, 32'h3C, 4, dout);
      check("R7", "bypass code", dout, 32'h78);

      // R9: external chain
      load_ir(4'h0, cap);
      @(negedge clk); tdi = 1'b1; #1;
      check("R9", "ext_si follows 1", 32'(ext_si), 32'h1);
      tdi = 1'b0; #1;
      check("R9", "ext_si follows 0", 32'(ext_si), 32'h0);
      scan_dr(16, 32'hC3A5, 7, dout);

      // R3: five high steps from mid Shift-DR
      step(1, 0, s); step(0, 0, s); step(0, 0, s); step(0, 1, s);
      repeat (5) step(1, 0, s);
      check("R3", "tlr from shift-dr", 32'(tap_state), 32'hF);
      check("R3", "instr back to idcode", 32'(cur_instr), 32'hE);
      @(negedge clk); tdi = 1'b1; #1;
      check("R9", "ext_si quiet", 32'(ext_si), 32'h0);
      step(0, 0, s);
      load_ir(4'hF, cap);
      step(1, 0, s); step(1, 0, s); step(0, 0, s); step(0, 0, s);
      repeat (5) step(1, 0, s);
      check("R3", "tlr from shift-ir", 32'(tap_state), 32'hF);
      check("R3", "instr idcode after shift-ir", 32'(cur_instr), 32'hE);

      // R2: asynchronous reset in mid-run
      step(0, 0, s);
      scan_dr(32, 32'hFFFF_0000, -1, dout);
      load_ir(4'h2, cap);
      scan_dr(5, 32'd7, -1, dout);
      check("R5", "chain 7", 32'(chain_num), 32'd7);
      step(1, 0, s);
      @(negedge clk); #1 rst_n = 1'b0; #1;
      check("R2", "async chain clear", 32'(chain_num), 32'd0);
      check("R2", "async state", 32'(tap_state), 32'hF);
      check("R2", "async instr", 32'(cur_instr), 32'hE);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step(0, 0, s);
      scan_dr(32, 32'h0, -1, dout);
      check("R6", "idcode after reset", dout, id_code);

      repeat (4) @(negedge clk);
      done = 1'b1;
      finish_run();
   end

endmodule